// File: doc/BRIEF.md
# DRAM Burst Refresh Sequencer

This block brackets a DRAM self-refresh period with two full refresh bursts. When the access arbiter raises a self-refresh request, the sequencer takes the DRAM pins. It runs one burst of refresh cycles over every row, then starts self refresh by pulling CAS low ahead of RAS and holding RAS low. After the request is withdrawn and the minimum self-refresh time has passed, it releases RAS, precharges, runs a second full burst and then hands the pins back. Normal read/write cycles, page-mode access and data paths belong to other logic.

Two refresh styles are supported, and the style is sampled when a sequence starts. In CAS-before-RAS style the DRAM counts rows itself and the address bus carries zero. In RAS-only style an internal row counter drives every row address once per burst, starting at row zero. A window watchdog measures the time from the start of each burst to the edge that ends it, and raises a sticky flag if that time exceeds a cycle-count limit. In CAS-before-RAS style the entry and exit windows are measured separately. In RAS-only style they share a single budget.

Top module: `refresh_burst_seq`

## Requirements
- R1: After reset, ras_n_o and cas_n_o are 1, addr_o is 0, and busy_o, self_ack_o, burst_done_o and win_viol_o are 0.
- R2: A high self_req_i in idle asserts busy_o on the next cycle. self_ack_o rises only after exactly 2^ROW_W refresh cycles (1024 by default) have been issued, and burst_done_o pulses in the cycle it rises.
- R3: With ras_only_i=0 (CAS-before-RAS), cas_n_o is low for at least T_CSR cycles before every RAS falling edge, and addr_o stays 0.
- R4: With ras_only_i=1 (RAS-only), cas_n_o stays high during burst cycles, and addr_o at the RAS falling edges of each burst counts 0, 1, ... 2^ROW_W-1 in order, restarting at 0 for the exit burst.
- R5: Every burst refresh cycle holds RAS low for exactly T_RAS cycles, and RAS is high for at least T_RP cycles before each falling edge.
- R6: Self refresh drives CAS low T_CSR cycles before RAS falls. RAS then stays low for at least T_SELF cycles and until self_req_i is low.
- R7: After self refresh, RAS is high for at least T_RP cycles, a second full burst runs, burst_done_o pulses once more, and busy_o returns to 0 with both strobes high.
- R8: win_viol_o sets when a window is open for more than WIN_CYC cycles. In CAS-before-RAS style the entry window (first burst RAS fall to self-refresh RAS fall) and the exit window (self-refresh RAS rise to last burst RAS fall) are each measured from zero. In RAS-only style both add into one count. The flag clears when the next sequence starts.
- R9: ras_only_i is sampled only when a sequence starts; changing it during a sequence has no effect on that sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| self_req_i | input | 1 | Self-refresh request from the arbiter (level) |
| ras_only_i | input | 1 | Refresh style: 1 RAS-only, 0 CAS-before-RAS |
| busy_o | output | 1 | Sequencer owns the DRAM pins |
| self_ack_o | output | 1 | Self refresh entered (entry burst complete) |
| burst_done_o | output | 1 | One-cycle pulse at the end of each burst |
| win_viol_o | output | 1 | Sticky refresh-window violation flag |
| ras_n_o | output | 1 | Row strobe, active low |
| cas_n_o | output | 1 | Column strobe, active low |
| addr_o | output | ROW_W | Row address for RAS-only refresh |

## Verification
The main function is tried with three sequences that run two instances side by side. The instances differ only in window length, and the short window sits between a CAS-before-RAS window and the shared RAS-only budget. A CAS-before-RAS sequence with an immediate release shows that the pins take the CAS-first ordering and that RAS is held for exactly the minimum self-refresh time. A RAS-only sequence with a long hold and a mode flip mid-way separates correct row ordering, mode latching and a hold that follows the request from the shared-window violation, which only the short instance must flag. A final CAS-before-RAS sequence shows that the sticky flag clears and that separate entry and exit windows do not trip the short instance.

// File: rtl/refresh_burst_pkg.sv
package refresh_burst_pkg;
  typedef enum logic [2:0] {
    ST_IDLE, ST_PRE_BURST, ST_SELF_ENTER, ST_SELF_HOLD,
    ST_SELF_EXIT, ST_POST_BURST, ST_DONE
  } seq_state_e;

  typedef enum logic [1:0] {PH_IDLE, PH_CSR, PH_RAS, PH_PRE} cyc_phase_e;
endpackage

// File: rtl/refresh_cycle_gen.sv
module refresh_cycle_gen import refresh_burst_pkg::*; #(
  parameter int T_CSR = 1,
  parameter int T_RAS = 3,
  parameter int T_RP  = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  input  logic cbr_i,
  output logic ras_n_o,
  output logic cas_n_o,
  output logic rdy_o,
  output logic done_o
);
  localparam int T_MAX = (T_CSR > T_RAS) ? ((T_CSR > T_RP) ? T_CSR : T_RP)
                                         : ((T_RAS > T_RP) ? T_RAS : T_RP);
  localparam int CNT_W = $clog2(T_MAX + 1);
  localparam logic [CNT_W-1:0] LD_CSR = CNT_W'(T_CSR - 1);
  localparam logic [CNT_W-1:0] LD_RAS = CNT_W'(T_RAS - 1);
  localparam logic [CNT_W-1:0] LD_RP  = CNT_W'(T_RP - 1);

  cyc_phase_e       phase_q, phase_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             cbr_q;

  assign done_o  = (phase_q == PH_PRE) && (cnt_q == '0);
  assign rdy_o   = (phase_q == PH_IDLE) || done_o;
  assign ras_n_o = (phase_q != PH_RAS);
  assign cas_n_o = !(cbr_q && (phase_q == PH_CSR || phase_q == PH_RAS));

  always_comb begin
    phase_d = phase_q;
    cnt_d   = cnt_q;
    if (phase_q != PH_IDLE && cnt_q != '0) begin
      cnt_d = cnt_q - 1'b1;
    end else begin
      unique case (phase_q)
        PH_CSR: begin phase_d = PH_RAS; cnt_d = LD_RAS; end
        PH_RAS: begin phase_d = PH_PRE; cnt_d = LD_RP;  end
        default: begin
          // precharge end doubles as the start slot of the next cycle
          if (start_i) begin
            phase_d = cbr_i ? PH_CSR : PH_RAS;
            cnt_d   = cbr_i ? LD_CSR : LD_RAS;
          end else begin
            phase_d = PH_IDLE;
          end
        end
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q <= PH_IDLE;
      cnt_q   <= '0;
      cbr_q   <= 1'b0;
    end else begin
      phase_q <= phase_d;
      cnt_q   <= cnt_d;
      if (start_i && rdy_o) cbr_q <= cbr_i;
    end
  end
endmodule

// File: rtl/refresh_row_counter.sv
module refresh_row_counter #(
  parameter int ROW_W = 10
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             inc_i,
  output logic [ROW_W-1:0] row_o,
  output logic             wrap_o
);
  logic [ROW_W-1:0] row_q;

  assign row_o  = row_q;
  assign wrap_o = inc_i && (row_q == '1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    row_q <= '0;
    else if (clr_i) row_q <= '0;
    else if (inc_i) row_q <= row_q + 1'b1;
  end
endmodule

// File: rtl/refresh_window.sv
module refresh_window #(
  parameter int WIN_CYC = 12000
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  input  logic clr_i,
  input  logic stop_i,
  input  logic viol_clr_i,
  output logic viol_o
);
  localparam int CNT_W = $clog2(WIN_CYC + 1);
  localparam logic [CNT_W-1:0] LIMIT = CNT_W'(WIN_CYC);

  logic [CNT_W-1:0] cnt_q;
  logic             active_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q    <= '0;
      active_q <= 1'b0;
      viol_o   <= 1'b0;
    end else begin
      if (start_i)     active_q <= 1'b1;
      else if (stop_i) active_q <= 1'b0;

      if (clr_i)                           cnt_q <= '0;
      else if (active_q && cnt_q != LIMIT) cnt_q <= cnt_q + 1'b1;

      // still open after LIMIT counted cycles: window exceeded
      if (viol_clr_i)                           viol_o <= 1'b0;
      else if (active_q && cnt_q == LIMIT)      viol_o <= 1'b1;
    end
  end
endmodule

// File: rtl/refresh_burst_seq.sv
module refresh_burst_seq import refresh_burst_pkg::*; #(
  parameter int ROW_W   = 10,
  parameter int T_CSR   = 1,
  parameter int T_RAS   = 3,
  parameter int T_RP    = 2,
  parameter int T_SELF  = 50,
  parameter int WIN_CYC = 12000
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             self_req_i,
  input  logic             ras_only_i,
  output logic             busy_o,
  output logic             self_ack_o,
  output logic             burst_done_o,
  output logic             win_viol_o,
  output logic             ras_n_o,
  output logic             cas_n_o,
  output logic [ROW_W-1:0] addr_o
);
  localparam int T_MAX = (T_CSR > T_SELF) ? ((T_CSR > T_RP) ? T_CSR : T_RP)
                                          : ((T_SELF > T_RP) ? T_SELF : T_RP);
  localparam int TMR_W = $clog2(T_MAX + 1);
  localparam logic [TMR_W-1:0] LD_CSR  = TMR_W'(T_CSR - 1);
  localparam logic [TMR_W-1:0] LD_SELF = TMR_W'(T_SELF - 1);
  localparam logic [TMR_W-1:0] LD_RP   = TMR_W'(T_RP - 1);
  localparam logic [ROW_W-1:0] ROW_LAST = '1;

  seq_state_e       state_q, state_d;
  logic [TMR_W-1:0] tmr_q, tmr_d;
  logic             mode_q;
  logic             in_burst, gen_start, gen_ras_n, gen_cas_n, gen_rdy, gen_done;
  logic             row_clr, row_inc, row_wrap, done_d;
  logic [ROW_W-1:0] row;
  logic             ras_d, cas_d;
  logic [ROW_W-1:0] addr_d;
  logic             fall_d, rise_d, first_fall, win_start, win_clr, win_stop;

  assign in_burst   = (state_q == ST_PRE_BURST) || (state_q == ST_POST_BURST);
  assign row_inc    = in_burst && gen_done;
  assign busy_o     = (state_q != ST_IDLE);
  assign self_ack_o = (state_q == ST_SELF_ENTER) || (state_q == ST_SELF_HOLD);

  refresh_cycle_gen #(.T_CSR(T_CSR), .T_RAS(T_RAS), .T_RP(T_RP)) u_gen (
    .clk_i, .rst_ni, .start_i(gen_start), .cbr_i(!mode_q),
    .ras_n_o(gen_ras_n), .cas_n_o(gen_cas_n), .rdy_o(gen_rdy), .done_o(gen_done)
  );

  refresh_row_counter #(.ROW_W(ROW_W)) u_rows (
    .clk_i, .rst_ni, .clr_i(row_clr), .inc_i(row_inc), .row_o(row), .wrap_o(row_wrap)
  );

  always_comb begin
    state_d   = state_q;
    tmr_d     = (tmr_q != '0) ? tmr_q - 1'b1 : '0;
    row_clr   = 1'b0;
    gen_start = 1'b0;
    done_d    = 1'b0;
    unique case (state_q)
      ST_IDLE: if (self_req_i) begin state_d = ST_PRE_BURST; row_clr = 1'b1; end
      ST_PRE_BURST: begin
        gen_start = gen_rdy && !row_wrap;
        if (row_wrap) begin state_d = ST_SELF_ENTER; tmr_d = LD_CSR; done_d = 1'b1; end
      end
      ST_SELF_ENTER: if (tmr_q == '0) begin state_d = ST_SELF_HOLD; tmr_d = LD_SELF; end
      ST_SELF_HOLD: if (tmr_q == '0 && !self_req_i) begin state_d = ST_SELF_EXIT; tmr_d = LD_RP; end
      ST_SELF_EXIT: if (tmr_q == '0) begin state_d = ST_POST_BURST; row_clr = 1'b1; end
      ST_POST_BURST: begin
        gen_start = gen_rdy && !row_wrap;
        if (row_wrap) begin state_d = ST_DONE; done_d = 1'b1; end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_comb begin
    ras_d  = 1'b1;
    cas_d  = 1'b1;
    addr_d = '0;
    if (in_burst) begin
      ras_d  = gen_ras_n;
      cas_d  = gen_cas_n;
      addr_d = mode_q ? row : '0;
    end else if (state_q == ST_SELF_ENTER) begin
      cas_d = 1'b0;
    end else if (state_q == ST_SELF_HOLD) begin
      ras_d = 1'b0;
      cas_d = 1'b0;
    end
  end

  // window edges are taken on the next pin values
  assign fall_d     = ras_n_o && !ras_d;
  assign rise_d     = !ras_n_o && ras_d;
  assign first_fall = (state_q == ST_PRE_BURST) && fall_d && (row == '0);
  assign win_start  = first_fall || ((state_q == ST_SELF_EXIT) && rise_d);
  assign win_clr    = first_fall || ((state_q == ST_SELF_EXIT) && rise_d && !mode_q);
  assign win_stop   = ((state_q == ST_SELF_HOLD) && fall_d) ||
                      ((state_q == ST_POST_BURST) && fall_d && (row == ROW_LAST));

  refresh_window #(.WIN_CYC(WIN_CYC)) u_win (
    .clk_i, .rst_ni, .start_i(win_start), .clr_i(win_clr), .stop_i(win_stop),
    .viol_clr_i((state_q == ST_IDLE) && self_req_i), .viol_o(win_viol_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q      <= ST_IDLE;
      tmr_q        <= '0;
      mode_q       <= 1'b0;
      ras_n_o      <= 1'b1;
      cas_n_o      <= 1'b1;
      addr_o       <= '0;
      burst_done_o <= 1'b0;
    end else begin
      state_q      <= state_d;
      tmr_q        <= tmr_d;
      ras_n_o      <= ras_d;
      cas_n_o      <= cas_d;
      addr_o       <= addr_d;
      burst_done_o <= done_d;
      if (state_q == ST_IDLE && self_req_i) mode_q <= ras_only_i;
    end
  end
endmodule

// File: rtl/refresh_burst_chk.sv
module refresh_burst_chk #(
  parameter int T_CSR  = 1,
  parameter int T_RAS  = 3,
  parameter int T_RP   = 2,
  parameter int T_SELF = 50
) (
  input logic clk_i,
  input logic rst_ni,
  input logic ras_n_i,
  input logic cas_n_i,
  input logic ack_i,
  input logic done_i,
  input logic busy_i,
  input logic ras_only_i
);
  int low_run, high_run, ack_run;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      low_run  <= 0;
      high_run <= 0;
      ack_run  <= 0;
    end else begin
      low_run  <= !ras_n_i ? low_run + 1 : 0;
      high_run <= ras_n_i ? high_run + 1 : 0;
      ack_run  <= ack_i ? ack_run + 1 : 0;
    end
  end

  AST_ACK_AFTER_BURST: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ack_i) |-> done_i); // R2
  AST_CBR_SETUP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($fell(ras_n_i) && !ras_only_i) |-> !cas_n_i); // R3
  AST_CAS_HIGH_RAS_ONLY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!cas_n_i && ras_only_i) |-> $past(ack_i)); // R4
  AST_RAS_LOW_MIN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ras_n_i) |-> (low_run >= T_RAS)); // R5
  AST_PRECHARGE_MIN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(ras_n_i) |-> (high_run >= T_RP)); // R5
  AST_SELF_MIN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(ack_i) |-> (ack_run >= T_CSR + T_SELF)); // R6
  AST_DONE_WHILE_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_i |-> busy_i); // R7
endmodule

bind refresh_burst_seq refresh_burst_chk #(
  .T_CSR(T_CSR), .T_RAS(T_RAS), .T_RP(T_RP), .T_SELF(T_SELF)
) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .ras_n_i(ras_n_o), .cas_n_i(cas_n_o),
  .ack_i(self_ack_o), .done_i(burst_done_o), .busy_i(busy_o), .ras_only_i(mode_q)
);

// File: tb/refresh_burst_seq_tb.sv
`timescale 1ns/1ps
module refresh_burst_seq_tb;
  localparam int ROW_W = 10, ROWS = 1 << ROW_W;
  localparam int T_CSR = 1, T_RAS = 3, T_RP = 2, T_SELF = 50;

  logic clk = 1'b0, rst_n = 1'b0, self_req = 1'b0, ras_only = 1'b0;
  logic busy, ack, bdone, viol, ras_n, cas_n;
  logic [ROW_W-1:0] addr;
  logic s_busy, s_ack, s_bdone, s_viol, s_ras_n, s_cas_n;
  logic [ROW_W-1:0] s_addr;

  always #10 clk = ~clk;

  refresh_burst_seq #(.ROW_W(ROW_W), .T_CSR(T_CSR), .T_RAS(T_RAS), .T_RP(T_RP),
    .T_SELF(T_SELF), .WIN_CYC(12000)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .self_req_i(self_req), .ras_only_i(ras_only),
    .busy_o(busy), .self_ack_o(ack), .burst_done_o(bdone), .win_viol_o(viol),
    .ras_n_o(ras_n), .cas_n_o(cas_n), .addr_o(addr));

  refresh_burst_seq #(.ROW_W(ROW_W), .T_CSR(T_CSR), .T_RAS(T_RAS), .T_RP(T_RP),
    .T_SELF(T_SELF), .WIN_CYC(8000)) u_dut_short (
    .clk_i(clk), .rst_ni(rst_n), .self_req_i(self_req), .ras_only_i(ras_only),
    .busy_o(s_busy), .self_ack_o(s_ack), .burst_done_o(s_bdone), .win_viol_o(s_viol),
    .ras_n_o(s_ras_n), .cas_n_o(s_cas_n), .addr_o(s_addr));

  int n_tests = 0, n_fail = 0;
  int exp_q[$];  // -1 CBR refresh, -2 self entry, >=0 RAS-only row
  int low_run = 0, high_run = 0, cas_run = 0, last_kind = 0;
  int fall_cnt = 0, done_cnt = 0, min_self_low = T_SELF;
  logic prev_ras = 1'b1, prev_ack = 1'b0;
  bit finished = 1'b0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // monitor: pops expected items at each RAS falling edge
  always @(negedge clk) if (rst_n && !finished) begin
    cas_run = !cas_n ? cas_run + 1 : 0;
    if (prev_ras && !ras_n) begin
      if (exp_q.size() == 0) begin
        chk(1'b0, "R2 unexpected RAS fall", fall_cnt, -1);
        last_kind = -1;
      end else begin
        last_kind = exp_q.pop_front();
        if (last_kind < 0) begin
          chk(cas_n == 1'b0, "R3 CAS low at RAS fall", cas_n, 0);
          chk(cas_run >= T_CSR + 1, "R6 CAS setup", cas_run, T_CSR + 1);
          if (last_kind == -1) chk(addr == '0, "R3 addr zero", addr, 0);
        end else begin
          chk(cas_n == 1'b1, "R4 CAS high", cas_n, 1);
          chk(addr == last_kind[ROW_W-1:0], "R4 row order", addr, last_kind);
        end
        if (last_kind != -2) chk(high_run >= T_RP, "R5 precharge", high_run, T_RP);
      end
      fall_cnt++;
      low_run = 1;
    end else if (!ras_n) begin
      low_run++;
    end else if (!prev_ras) begin
      if (last_kind == -2) chk(low_run >= min_self_low, "R6 self hold", low_run, min_self_low);
      else chk(low_run == T_RAS, "R5 RAS low", low_run, T_RAS);
      high_run = 1;
    end else begin
      high_run++;
    end
    if (ack && !prev_ack) chk(fall_cnt == ROWS, "R2 ack after burst", fall_cnt, ROWS);
    if (ack && !prev_ack) chk(bdone == 1'b1, "R2 done with ack", bdone, 1);
    if (bdone) done_cnt++;
    prev_ras = ras_n;
    prev_ack = ack;
  end

  // driver: queues the expected pin items, then runs one sequence
  task automatic run_seq(input bit ro, input int hold, input bit flip, input bit exp_short);
    for (int i = 0; i < 2; i++) begin
      for (int r = 0; r < ROWS; r++) exp_q.push_back(ro ? r : -1);
      if (i == 0) exp_q.push_back(-2);
    end
    fall_cnt = 0;
    done_cnt = 0;
    min_self_low = (hold - T_CSR - 1 > T_SELF) ? hold - T_CSR - 1 : T_SELF;
    @(negedge clk);
    ras_only = ro;
    self_req = 1'b1;
    @(negedge clk);
    chk(busy == 1'b1, "R2 busy", busy, 1);
    while (!ack) @(negedge clk);
    repeat (hold) @(negedge clk);
    self_req = 1'b0;
    if (flip) ras_only = !ro;  // R9: must not change this sequence
    while (busy) @(negedge clk);
    @(negedge clk);
    chk(exp_q.size() == 0, "R7 all items seen", exp_q.size(), 0);
    chk(done_cnt == 2, "R7 burst_done pulses", done_cnt, 2);
    chk(fall_cnt == 2 * ROWS + 1, flip ? "R9 mode held" : "R7 fall count", fall_cnt, 2 * ROWS + 1);
    chk(ras_n && cas_n, "R7 strobes released", {ras_n, cas_n}, 3);
    chk(viol == 1'b0, "R8 long window", viol, 0);
    chk(s_viol == exp_short, "R8 short window", s_viol, exp_short);
    exp_q.delete();
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(ras_n && cas_n, "R1 strobes", {ras_n, cas_n}, 3);
    chk(addr == '0, "R1 addr", addr, 0);
    chk(!busy && !ack && !bdone && !viol, "R1 flags", {busy, ack, bdone, viol}, 0);
    run_seq(1'b0, 0, 1'b0, 1'b0);    // CBR, minimum self refresh
    run_seq(1'b1, 200, 1'b1, 1'b1);  // RAS-only, long hold, shared window trips short
    run_seq(1'b0, 5, 1'b0, 1'b0);    // CBR again: sticky flag cleared
    finished = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule